// File: doc/BRIEF.md
# Real-Time Clock Down-Counter

This block is a 23-bit down-counting real-time clock and system timer for a single system clock domain. A multiplexer picks one of six slow timing sources. The pick depends on a three-bit oscillator configuration code, an RC-clock selector bit and a two-bit source field in the control register. The chosen source passes through a synchroniser, and each rising edge of it becomes a one-cycle tick.

While the block is enabled and not powered down, each tick lowers the count by one. When a tick finds the count at zero, the counter reloads from a software-written reload register. A sticky terminal flag marks each arrival at zero. The flag drives an interrupt request that shares one output with an external watchdog interrupt.

Software reaches the block through a plain byte-wide register port. The port has a single-cycle write strobe and combinational read data. The control, reload and count bytes sit at fixed addresses.

Top module: `rtc_down_timer`

## Requirements
- R1: After reset, the control byte (address 0) reads 0x60: enable 0, interrupt enable 0, source field 11, flag 0. Addresses 1 to 7 read 0x00, `count_o` is 0 and `irq` equals `wdt_irq`.
- R2: The control byte layout is: bit 0 enable, bit 1 interrupt enable, bits 6:5 source field, bit 7 flag. Bits 4:2 ignore writes and read 0, and writing 1 to bit 7 never sets the flag.
- R3: Addresses 1, 2 and 3 write and read the reload value. Address 1 holds bits 7:0 and address 2 holds bits 15:8. Address 3 holds bits 22:16, and its bit 7 reads 0. Addresses 4, 5 and 6 read the count bytes in the same order.
- R4: Take a rising edge of the selected source that is first sampled high at system clock edge k. While enabled and not powered down, that edge changes the count at edge k+2. A non-zero count drops by exactly one.
- R5: With the enable bit at 0, the count holds.
- R6: While `pwr_down` is 1, the count holds whatever the enable bit holds.
- R7: A tick that finds the count at zero loads the reload value, and counting continues down from there.
- R8: A tick that leaves the count at zero sets the flag. If a clear write lands in the same cycle, the set wins.
- R9: A control write with bit 7 at 0 clears the flag. A write with bit 7 at 1 leaves it unchanged.
- R10: `irq` is high exactly when `wdt_irq` is 1, or when the flag and the interrupt enable are both 1.
- R11: The source map for every configuration code except 101, 110 and 111 is as follows. Field 00 picks `hf_xtal`, 01 picks `mf_xtal` and 10 picks `lf_xtal`. Field 11 picks `cpu_div_clk` when `rc_clk_sel` is 0 and `rc_osc` when it is 1.
- R12: With configuration code 111, fields 00, 01 and 10 pick `ext_clk`. Field 11 picks `ext_clk` when `rc_clk_sel` is 0 and `rc_osc` when it is 1.
- R13: Configuration codes 101 and 110 select no source. Once such a code has been held for three system clocks, no tick occurs and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1-3 reload, 4-6 count) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| osc_cfg | input | 3 | Oscillator configuration code |
| rc_clk_sel | input | 1 | RC-clock selector bit |
| hf_xtal | input | 1 | High-frequency crystal level |
| mf_xtal | input | 1 | Medium-frequency crystal level |
| lf_xtal | input | 1 | Low-frequency crystal level |
| cpu_div_clk | input | 1 | Divided CPU clock level |
| rc_osc | input | 1 | Internal RC oscillator level |
| ext_clk | input | 1 | External clock input level |
| pwr_down | input | 1 | Power-down; freezes the counter |
| wdt_irq | input | 1 | Watchdog interrupt request, shared |
| irq | output | 1 | Shared interrupt request |
| count_o | output | 23 | Current count |

## Verification
The assertions assume that every source input holds each level for at least two system clocks, so the synchroniser sees each rising edge exactly once. They also assume that the configuration code, selector bits and `pwr_down` change only between clock edges. The stimulus meets these assumptions. It drives every source as a square wave with a half-period of two to seven clocks, and it changes all inputs on the falling edge. The undefined-code check only starts after the code has been stable for three clocks. Any spurious tick caused by switching between a low source and a high one is therefore left to the reference model, which predicts it from the same multiplexer sequence.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [2:0] OSC_CODE_NONE_A = 3'b101;
  localparam logic [2:0] OSC_CODE_NONE_B = 3'b110;
  localparam logic [2:0] OSC_CODE_EXT    = 3'b111;

  localparam logic [1:0] SRC_HF  = 2'b00;
  localparam logic [1:0] SRC_MF  = 2'b01;
  localparam logic [1:0] SRC_LF  = 2'b10;
  localparam logic [1:0] SRC_AUX = 2'b11;

  localparam int BIT_RUN  = 0;
  localparam int BIT_IEN  = 1;
  localparam int BIT_SEL0 = 5;
  localparam int BIT_SEL1 = 6;
  localparam int BIT_TERM = 7;

  typedef struct packed {
    logic       term;
    logic [1:0] sel;
    logic       ien;
    logic       run;
  } rtc_ctrl_t;

  function automatic logic osc_code_silent(input logic [2:0] code);
    return (code == OSC_CODE_NONE_A) || (code == OSC_CODE_NONE_B);
  endfunction

endpackage

// File: rtl/rtc_src_select.sv
module rtc_src_select
  import rtc_pkg::*;
(
  input  logic [2:0] osc_cfg,
  input  logic       rc_clk_sel,
  input  logic [1:0] sel,
  input  logic       hf_xtal,
  input  logic       mf_xtal,
  input  logic       lf_xtal,
  input  logic       cpu_div_clk,
  input  logic       rc_osc,
  input  logic       ext_clk,
  output logic       src_level
);

  logic aux_level;
  logic xtal_level;

  // Field 11 picks the RC oscillator whenever the selector bit is set.
  always_comb begin
    if (rc_clk_sel)
      aux_level = rc_osc;
    else if (osc_cfg == OSC_CODE_EXT)
      aux_level = ext_clk;
    else
      aux_level = cpu_div_clk;
  end

  always_comb begin
    unique case (sel)
      SRC_HF:  xtal_level = hf_xtal;
      SRC_MF:  xtal_level = mf_xtal;
      SRC_LF:  xtal_level = lf_xtal;
      default: xtal_level = 1'b0;
    endcase
  end

  always_comb begin
    if (osc_code_silent(osc_cfg))
      src_level = 1'b0;
    else if (sel == SRC_AUX)
      src_level = aux_level;
    else if (osc_cfg == OSC_CODE_EXT)
      src_level = ext_clk;
    else
      src_level = xtal_level;
  end

endmodule

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  output logic tick
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("rtc_tick_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], src_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign tick = sync_q[STAGES-1] & ~last_q;

  // R4: one source edge gives one single-cycle tick
  p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_pkg::*;
#(
  parameter int CNT_W  = 23,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              term_set,
  input  logic [CNT_W-1:0]  count,
  output rtc_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int NBYTES     = (CNT_W + DATA_W - 1) / DATA_W;
  localparam int RELOAD_LO  = 1;
  localparam int COUNT_LO   = RELOAD_LO + NBYTES;

  function automatic logic [DATA_W-1:0] slice_byte(input logic [CNT_W-1:0] v,
                                                   input int idx);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_W; i++)
      if (idx * DATA_W + i < CNT_W) r[i] = v[idx*DATA_W+i];
    return r;
  endfunction

  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.run <= 1'b0;
      ctrl.ien <= 1'b0;
      ctrl.sel <= 2'b11;
    end else if (ctrl_wr) begin
      ctrl.run <= reg_wdata[BIT_RUN];
      ctrl.ien <= reg_wdata[BIT_IEN];
      ctrl.sel <= {reg_wdata[BIT_SEL1], reg_wdata[BIT_SEL0]};
    end
  end

  // Set from the counter wins over a software clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl.term <= 1'b0;
    else if (term_set)
      ctrl.term <= 1'b1;
    else if (ctrl_wr && !reg_wdata[BIT_TERM])
      ctrl.term <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
    end else if (reg_wr) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (int'(reg_addr) == RELOAD_LO + b) begin
          for (int i = 0; i < DATA_W; i++)
            if (b * DATA_W + i < CNT_W) reload[b*DATA_W+i] <= reg_wdata[i];
        end
      end
    end
  end

  always_comb begin
    int a;
    a = int'(reg_addr);
    reg_rdata = '0;
    if (a == 0) begin
      reg_rdata[BIT_RUN]  = ctrl.run;
      reg_rdata[BIT_IEN]  = ctrl.ien;
      reg_rdata[BIT_SEL0] = ctrl.sel[0];
      reg_rdata[BIT_SEL1] = ctrl.sel[1];
      reg_rdata[BIT_TERM] = ctrl.term;
    end else if (a >= RELOAD_LO && a < COUNT_LO) begin
      reg_rdata = slice_byte(reload, a - RELOAD_LO);
    end else if (a >= COUNT_LO && a < COUNT_LO + NBYTES) begin
      reg_rdata = slice_byte(count, a - COUNT_LO);
    end
  end

  // R8: a terminal tick always leaves the flag set
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    term_set |=> ctrl.term);

  // R9: a clear write with no competing set drops the flag
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !reg_wdata[BIT_TERM] && !term_set) |=> !ctrl.term);

  // R9: the flag stays set unless a clear write arrives
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.term && !(ctrl_wr && !reg_wdata[BIT_TERM])) |=> ctrl.term);

  // R2: software cannot raise the flag
  p_flag_no_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.term && !term_set) |=> !ctrl.term);

endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             term_hit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_zero;
  assign at_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (tick_en)
      count <= at_zero ? reload : count - ONE;
  end

  // The tick that leaves the counter at zero.
  assign term_hit = tick_en && ((count == ONE) || (at_zero && reload == '0));

  // R5: no tick, no change
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));

  // R4: a tick on a non-zero count subtracts one
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && count != '0) |=> (count == $past(count) - ONE));

  // R7: a tick at zero loads the reload value
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && count == '0) |=> (count == $past(reload)));

  // R8: the flag-setting tick lands the counter on zero
  p_term_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |=> (count == '0));

endmodule

// File: rtl/rtc_down_timer.sv
module rtc_down_timer
  import rtc_pkg::*;
#(
  parameter int CNT_W       = 23,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [2:0]        osc_cfg,
  input  logic              rc_clk_sel,
  input  logic              hf_xtal,
  input  logic              mf_xtal,
  input  logic              lf_xtal,
  input  logic              cpu_div_clk,
  input  logic              rc_osc,
  input  logic              ext_clk,
  input  logic              pwr_down,
  input  logic              wdt_irq,
  output logic              irq,
  output logic [CNT_W-1:0]  count_o
);

  rtc_ctrl_t        ctrl;
  logic [CNT_W-1:0] reload;
  logic             src_level;
  logic             src_tick;
  logic             tick_en;
  logic             term_hit;

  rtc_src_select u_src (
    .osc_cfg     (osc_cfg),
    .rc_clk_sel  (rc_clk_sel),
    .sel         (ctrl.sel),
    .hf_xtal     (hf_xtal),
    .mf_xtal     (mf_xtal),
    .lf_xtal     (lf_xtal),
    .cpu_div_clk (cpu_div_clk),
    .rc_osc      (rc_osc),
    .ext_clk     (ext_clk),
    .src_level   (src_level)
  );

  rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_in (src_level),
    .tick   (src_tick)
  );

  // Power-down overrides the enable bit.
  assign tick_en = src_tick & ctrl.run & ~pwr_down;

  rtc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .reload   (reload),
    .count    (count_o),
    .term_hit (term_hit)
  );

  rtc_ctrl_regs #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .term_set  (term_hit),
    .count     (count_o),
    .ctrl      (ctrl),
    .reload    (reload),
    .reg_rdata (reg_rdata)
  );

  assign irq = wdt_irq | (ctrl.term & ctrl.ien);

  // Checker state: how long the configuration code has named no source.
  logic [1:0] silent_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      silent_run <= '0;
    else if (!osc_code_silent(osc_cfg))
      silent_run <= '0;
    else if (silent_run != 2'd3)
      silent_run <= silent_run + 2'd1;
  end

  // R6: power-down freezes the count
  p_pd_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> $stable(count_o));

  // R13: a settled undefined code yields no tick
  p_silent_no_tick_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (silent_run == 2'd3) |-> !src_tick);

  // R10: a pending enabled flag reaches the shared request
  p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[BIT_TERM] && reg_addr == '0 && ctrl.ien) |-> irq);

  // R10: no cause, no request
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_irq && !ctrl.term) |-> !irq);

endmodule

// File: tb/rtc_down_timer_tb.sv
module rtc_down_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [2:0]  osc_cfg = 3'b100;
  logic        rc_clk_sel = 1'b0;
  logic        hf_xtal = 1'b0, mf_xtal = 1'b0, lf_xtal = 1'b0;
  logic        cpu_div_clk = 1'b0, rc_osc = 1'b0, ext_clk = 1'b0;
  logic        pwr_down = 1'b0;
  logic        wdt_irq = 1'b0;
  logic        irq;
  logic [22:0] count_o;

  always #5 clk = ~clk;

  rtc_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .osc_cfg(osc_cfg),
    .rc_clk_sel(rc_clk_sel), .hf_xtal(hf_xtal), .mf_xtal(mf_xtal),
    .lf_xtal(lf_xtal), .cpu_div_clk(cpu_div_clk), .rc_osc(rc_osc),
    .ext_clk(ext_clk), .pwr_down(pwr_down), .wdt_irq(wdt_irq),
    .irq(irq), .count_o(count_o)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    flag_rises = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int unsigned m_cnt, m_rel;
  bit m_run, m_ien, m_flag;
  bit [1:0] m_sel;
  bit src_hist[$];

  function automatic bit ref_source();
    if (osc_cfg == 3'b101 || osc_cfg == 3'b110) return 1'b0;
    if (osc_cfg == 3'b111) return (m_sel == 2'b11 && rc_clk_sel) ? rc_osc : ext_clk;
    case (m_sel)
      2'b00:   return hf_xtal;
      2'b01:   return mf_xtal;
      2'b10:   return lf_xtal;
      default: return rc_clk_sel ? rc_osc : cpu_div_clk;
    endcase
  endfunction

  function automatic bit [7:0] ref_read(input int a);
    case (a)
      0: return {m_flag, m_sel, 3'b000, m_ien, m_run};
      1: return m_rel[7:0];
      2: return m_rel[15:8];
      3: return {1'b0, m_rel[22:16]};
      4: return m_cnt[7:0];
      5: return m_cnt[15:8];
      6: return {1'b0, m_cnt[22:16]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model advances on each edge, then compares.
  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        m_cnt = 0; m_rel = 0; m_run = 0; m_ien = 0; m_flag = 0; m_sel = 2'b11;
        src_hist = '{1'b0, 1'b0, 1'b0};
      end else begin
        bit tick, te, hit, clr, srcv;
        srcv = ref_source();
        tick = src_hist[1] && !src_hist[2];
        te   = tick && m_run && !pwr_down;
        hit  = 1'b0;
        if (te) begin
          if (m_cnt == 0) m_cnt = m_rel; else m_cnt = m_cnt - 1;
          hit = (m_cnt == 0);
        end
        clr = 1'b0;
        if (reg_wr) begin
          case (reg_addr)
            3'd0: begin
              m_run = reg_wdata[0]; m_ien = reg_wdata[1];
              m_sel = {reg_wdata[6], reg_wdata[5]}; clr = !reg_wdata[7];
            end
            3'd1: m_rel[7:0]   = reg_wdata;
            3'd2: m_rel[15:8]  = reg_wdata;
            3'd3: m_rel[22:16] = reg_wdata[6:0];
            default: ;
          endcase
        end
        if (hit) begin
          if (!m_flag) flag_rises++;
          m_flag = 1'b1;
        end else if (clr) m_flag = 1'b0;
        src_hist.push_front(srcv);
        void'(src_hist.pop_back());
        #1;
        check(cur_req, "count", int'(count_o), int'(m_cnt));
        check(cur_req, "rdata", int'(reg_rdata), int'(ref_read(int'(reg_addr))));
        check("R10", "irq", int'(irq), int'(wdt_irq | (m_flag & m_ien)));
      end
    end
  end

  // Slow square-wave sources, changed on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      hf_xtal     = (cyc / 2) % 2;
      mf_xtal     = (cyc / 3) % 2;
      lf_xtal     = (cyc / 5) % 2;
      cpu_div_clk = (cyc / 4) % 2;
      rc_osc      = (cyc / 6) % 2;
      ext_clk     = (cyc / 7) % 2;
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, "readback", int'(reg_rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_check(input int n, input string req);
    int snap;
    idle(4);
    snap = int'(count_o);
    idle(n);
    check(req, "held count", int'(count_o), snap);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    rd_chk(3'd0, 8'h60, "R1");
    for (int a = 1; a < 8; a++) rd_chk(3'(a), 0, "R1");
    check("R1", "count after reset", int'(count_o), 0);
    check("R1", "irq after reset", int'(irq), 0);
    // R2 reserved bits and flag bit
    cur_req = "R2";
    wr_reg(3'd0, 8'h1C);
    rd_chk(3'd0, 8'h00, "R2");
    wr_reg(3'd0, 8'hFF);
    rd_chk(3'd0, 8'h63, "R2");
    wr_reg(3'd0, 8'h00);
    // R3 reload register bytes
    cur_req = "R3";
    wr_reg(3'd1, 8'hAB); wr_reg(3'd2, 8'hCD); wr_reg(3'd3, 8'hFF);
    rd_chk(3'd1, 8'hAB, "R3");
    rd_chk(3'd2, 8'hCD, "R3");
    rd_chk(3'd3, 8'h7F, "R3");
    wr_reg(3'd1, 8'h06); wr_reg(3'd2, 8'h00); wr_reg(3'd3, 8'h00);
    // R4 R7 R8 counting, reload, flag on high-frequency crystal
    cur_req = "R4";
    osc_cfg = 3'b100;
    wr_reg(3'd0, 8'h03);
    idle(30);
    cur_req = "R7";
    idle(60);
    check("R8", "flag set seen", int'(flag_rises > 0), 1);
    // R9 flag clear semantics
    cur_req = "R9";
    wr_reg(3'd0, 8'h83);
    idle(3);
    wr_reg(3'd0, 8'h01);
    idle(20);
    // R10 shared interrupt
    cur_req = "R10";
    wdt_irq = 1'b1; idle(5); wdt_irq = 1'b0;
    wr_reg(3'd0, 8'h03); idle(40);
    // R11 map for crystal-style codes
    cur_req = "R11";
    wr_reg(3'd1, 8'h09);
    wr_reg(3'd0, 8'h23); idle(40);
    wr_reg(3'd0, 8'h43); idle(60);
    wr_reg(3'd0, 8'h63); idle(50);
    rc_clk_sel = 1'b1; idle(60);
    osc_cfg = 3'b000; rc_clk_sel = 1'b0;
    wr_reg(3'd0, 8'h03); idle(30);
    // R12 external clock code
    cur_req = "R12";
    osc_cfg = 3'b111;
    for (int s = 0; s < 4; s++) begin
      wr_reg(3'd0, 8'(8'h03 | (s << 5)));
      idle(45);
    end
    rc_clk_sel = 1'b1; idle(60);
    rc_clk_sel = 1'b0;
    // R13 undefined codes hold
    cur_req = "R13";
    osc_cfg = 3'b101; hold_check(40, "R13");
    osc_cfg = 3'b110; hold_check(40, "R13");
    // R6 power-down overrides enable
    cur_req = "R6";
    osc_cfg = 3'b100;
    wr_reg(3'd0, 8'h03);
    pwr_down = 1'b1; hold_check(40, "R6");
    pwr_down = 1'b0; idle(20);
    // R5 enable cleared
    cur_req = "R5";
    wr_reg(3'd0, 8'h02);
    hold_check(40, "R5");
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule